// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block picks the receive buffer, if any, that takes an incoming CAN frame identifier. Each of sixteen buffer slots holds a programmed 29-bit identifier, an extended-format flag and a receive-enable flag. When the frame decoder pulses `idValid` with an identifier and its format bit, every slot compares the frame against its own programmed value under a mask. Slots 0 to 13 share one common mask. Slots 14 and 15 each have a private mask. The same masks apply to standard and extended frames.

The result appears one clock after the strobe. It consists of a per-slot match vector, a hit flag, and the index of the lowest-numbered matching slot. The result holds until the next strobe. Slot and mask contents are loaded through a single-cycle register write port. For a standard frame, the 11-bit identifier sits in the top 11 bits of the 29-bit field, and only those bits take part in the comparison. Masks should only be rewritten while no frames are arriving. A frame that was accepted under an old mask may fail to match under a new one.

Top module: `canAcceptFilter`

## Requirements
- R1: A write (`wrEn`=1) to address 0..15 loads that slot: data bits [28:0] are the identifier, bit 29 the extended flag, bit 30 the receive enable. Address 16 loads the common mask, address 17 the private mask of slot 14, and address 18 the private mask of slot 15, each from data bits [28:0].
- R2: After reset all slots are disabled, every mask is all ones (exact match required), and `matchVec`, `hitValid` and `hitIndex` are zero.
- R3: A mask bit of 0 makes that identifier bit don't-care. A mask bit of 1 requires the frame bit to equal the slot's programmed bit.
- R4: Slots 0..13 are compared under the common mask. Slot 14 uses its own private mask and slot 15 uses its own private mask. A change to one mask has no effect on slots that use another mask.
- R5: For a standard frame (`frameIde`=0), only identifier bits [28:18] are compared. For an extended frame, all 29 bits are compared.
- R6: A slot matches only if its receive enable is 1 and its extended flag equals `frameIde`.
- R7: `hitValid` is 1 when any slot matches, and `hitIndex` then gives the lowest-numbered matching slot. With no match, `hitValid`, `hitIndex` and `matchVec` are all zero.
- R8: The outputs take the result for the values present at the clock edge that samples `idValid`=1, using the slot and mask contents held before any write on that same edge. With `idValid`=0 the outputs hold, even across register writes.
- R9: Writes to addresses 19..31 change no slot and no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 31 | Register write data |
| idValid | input | 1 | Frame identifier present, one-cycle strobe |
| frameId | input | 29 | Incoming identifier (standard form in bits [28:18]) |
| frameIde | input | 1 | Incoming frame is extended format |
| matchVec | output | 16 | Per-slot match result |
| hitValid | output | 1 | At least one slot matched |
| hitIndex | output | 4 | Lowest-numbered matching slot |

## Verification
The hardest situations to create from the ports are near-misses. These are frames that differ from a slot only in a masked-off bit, only in a bit outside the standard window, or only in the format flag, while several slots compete for the lowest index. The sweep reprograms all sixteen slots and three masks in many rounds. It uses sparse masks and derives each frame from a chosen slot's identifier with a few bits flipped, so partial and multiple matches occur often. Directed cases then isolate each mask's reach, the standard/extended window, the hold behaviour across writes, and unmapped writes.

// File: rtl/canFiltPkg.sv
package canFiltPkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DATA_W = ID_W + 2;
  localparam int MASK_N = 3;

  localparam logic [ID_W-1:0] STD_WIN = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  typedef struct packed {
    logic            en;
    logic            ide;
    logic [ID_W-1:0] id;
  } slotCfg_t;

  typedef struct packed {
    logic       capture;
    logic       bufWe;
    logic       maskWe;
    logic [1:0] maskIdx;
  } filtStrb_t;
endpackage

// File: rtl/canFiltCtrl.sv
module canFiltCtrl
  import canFiltPkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              idValid,
  output filtStrb_t         strb
);
  localparam logic [ADDR_W-1:0] MASK_BASE = ADDR_W'(NUM_BUF);
  localparam logic [ADDR_W-1:0] MASK_END  = ADDR_W'(NUM_BUF + MASK_N);

  always_comb begin
    strb.capture = idValid;
    strb.bufWe   = wrEn && (wrAddr < MASK_BASE);
    strb.maskWe  = wrEn && (wrAddr >= MASK_BASE) && (wrAddr < MASK_END);
    strb.maskIdx = 2'(wrAddr - MASK_BASE);
  end

  assert_strb_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.bufWe && strb.maskWe));
  assert_mask_idx_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWe |-> (strb.maskIdx != 2'd3));
endmodule

// File: rtl/canFiltSlot.sv
module canFiltSlot
  import canFiltPkg::*;
(
  input  slotCfg_t        cfg,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] frameId,
  input  logic            frameIde,
  output logic            hit
);
  logic [ID_W-1:0] effMask;
  logic [ID_W-1:0] diff;

  always_comb begin
    effMask = frameIde ? mask : (mask & STD_WIN);
    diff    = (frameId ^ cfg.id) & effMask;
    hit     = cfg.en && (cfg.ide == frameIde) && (diff == '0);
  end
endmodule

// File: rtl/canFiltPrio.sv
module canFiltPrio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/canFiltDp.sv
module canFiltDp
  import canFiltPkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtStrb_t         strb,
  input  logic [IDX_W-1:0]  bufIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]   frameId,
  input  logic              frameIde,
  output logic [NUM_BUF-1:0] matchVec,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitIndex
);
  localparam int PRIV_BASE = NUM_BUF - 2;

  slotCfg_t        slotReg [NUM_BUF];
  logic [ID_W-1:0] globMask;
  logic [ID_W-1:0] privMask [2];

  logic [NUM_BUF-1:0] hitComb;
  logic [IDX_W-1:0]   idxComb;
  logic               anyComb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) slotReg[i] <= '0;
      globMask    <= '1;
      privMask[0] <= '1;
      privMask[1] <= '1;
    end else begin
      if (strb.bufWe) slotReg[bufIdx] <= slotCfg_t'(wrData);
      if (strb.maskWe) begin
        case (strb.maskIdx)
          2'd0:    globMask    <= wrData[ID_W-1:0];
          2'd1:    privMask[0] <= wrData[ID_W-1:0];
          2'd2:    privMask[1] <= wrData[ID_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : gSlot
    if (g >= PRIV_BASE) begin : gPriv
      canFiltSlot slot_i (
        .cfg(slotReg[g]), .mask(privMask[g - PRIV_BASE]),
        .frameId(frameId), .frameIde(frameIde), .hit(hitComb[g]));
    end else begin : gGlob
      canFiltSlot slot_i (
        .cfg(slotReg[g]), .mask(globMask),
        .frameId(frameId), .frameIde(frameIde), .hit(hitComb[g]));
    end

    assert_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.capture && !slotReg[g].en) |=> !matchVec[g]);
    assert_format_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.capture && (slotReg[g].ide != frameIde)) |=> !matchVec[g]);
  end

  canFiltPrio #(.N(NUM_BUF), .IDX_W(IDX_W)) prio_i (
    .vec(hitComb), .idx(idxComb), .any(anyComb));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVec <= '0;
      hitValid <= 1'b0;
      hitIndex <= '0;
    end else if (strb.capture) begin
      matchVec <= hitComb;
      hitValid <= anyComb;
      hitIndex <= idxComb;
    end
  end

  logic [NUM_BUF-1:0] belowHit;
  assign belowHit = (NUM_BUF'(1) << hitIndex) - NUM_BUF'(1);

  assert_lowest_R7: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (matchVec[hitIndex] && ((matchVec & belowHit) == '0)));
  assert_nomatch_R7: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (matchVec == '0 && hitIndex == '0));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(matchVec) && $stable(hitValid) && $stable(hitIndex)));
endmodule

// File: rtl/canAcceptFilter.sv
module canAcceptFilter
  import canFiltPkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = $clog2(NUM_BUF + MASK_N),
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               idValid,
  input  logic [ID_W-1:0]    frameId,
  input  logic               frameIde,
  output logic [NUM_BUF-1:0] matchVec,
  output logic               hitValid,
  output logic [IDX_W-1:0]   hitIndex
);
  filtStrb_t strb;

  canFiltCtrl #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .idValid(idValid), .strb(strb));

  canFiltDp #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bufIdx(wrAddr[IDX_W-1:0]),
    .wrData(wrData), .frameId(frameId), .frameIde(frameIde),
    .matchVec(matchVec), .hitValid(hitValid), .hitIndex(hitIndex));
endmodule

// File: tb/canAcceptFilter_tb.sv
`timescale 1ns/1ps
module canAcceptFilter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [30:0] wrData = '0;
  logic        idValid = 1'b0;
  logic [28:0] frameId = '0;
  logic        frameIde = 1'b0;
  logic [15:0] matchVec;
  logic        hitValid;
  logic [3:0]  hitIndex;

  int checks = 0;
  int errors = 0;
  logic [31:0] rs = 32'h1badcafe;

  logic        sEn  [16];
  logic        sIde [16];
  logic [28:0] sId  [16];
  logic [28:0] sMask [3];

  localparam logic [28:0] WIN = {11'h7FF, 18'h0};

  always #10 clk = ~clk;

  canAcceptFilter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .idValid(idValid), .frameId(frameId), .frameIde(frameIde),
    .matchVec(matchVec), .hitValid(hitValid), .hitIndex(hitIndex));

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [15:0] modelVec(logic [28:0] fid, logic fide);
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      logic [28:0] m = (i < 14) ? sMask[0] : sMask[i - 13];
      if (!fide) m = m & WIN;
      v[i] = sEn[i] && (sIde[i] == fide) && (((fid ^ sId[i]) & m) == '0);
    end
    return v;
  endfunction

  function automatic logic [3:0] lowIdx(logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic regWrite(input logic [4:0] a, input logic [30:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a < 16) begin
      sId[a] = d[28:0]; sIde[a] = d[29]; sEn[a] = d[30];
    end else if (a < 19) begin
      sMask[a - 16] = d[28:0];
    end
  endtask

  task automatic sendFrame(input logic [28:0] id, input logic ide);
    @(negedge clk);
    idValid = 1'b1; frameId = id; frameIde = ide;
    @(negedge clk);
    idValid = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] ev);
    logic       evld = |ev;
    logic [3:0] eidx = lowIdx(ev);
    checks++;
    if (matchVec !== ev || hitValid !== evld || hitIndex !== eidx) begin
      errors++;
      $display("FAIL %s: vec=%h valid=%b idx=%0d expected vec=%h valid=%b idx=%0d",
               req, matchVec, hitValid, hitIndex, ev, evld, eidx);
    end
  endtask

  task automatic resetAll();
    rstN = 1'b0;
    for (int i = 0; i < 16; i++) begin sEn[i] = 0; sIde[i] = 0; sId[i] = '0; end
    for (int i = 0; i < 3; i++) sMask[i] = '1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    resetAll();
    // R2: outputs zero after reset
    check("R2 reset outputs", 16'h0);
    // R2/R3: default masks are all ones, so one differing bit misses
    regWrite(5'd0, {1'b1, 1'b1, 29'h1234567});
    sendFrame(29'h1234566, 1'b1);
    check("R2 default mask exact", 16'h0);
    sendFrame(29'h1234567, 1'b1);
    check("R1 slot load exact hit", 16'h0001);
    // R9: unmapped writes of zero must not clear masks or slots
    for (int a = 19; a < 32; a++) regWrite(5'(a), 31'h0);
    sendFrame(29'h1234566, 1'b1);
    check("R9 unmapped no mask change", 16'h0);
    sendFrame(29'h1234567, 1'b1);
    check("R9 unmapped no slot change", 16'h0001);

    // R4: per-mask reach. All slots extended id 0, enabled.
    for (int i = 0; i < 16; i++) regWrite(5'(i), {1'b1, 1'b1, 29'h0});
    regWrite(5'd16, 31'h1FFFFFFE);
    sendFrame(29'h1, 1'b1);
    check("R4 common mask covers 0..13", 16'h3FFF);
    regWrite(5'd17, 31'h1FFFFFFE);
    sendFrame(29'h1, 1'b1);
    check("R4 private mask slot 14", 16'h7FFF);
    regWrite(5'd16, 31'h1FFFFFFF);
    regWrite(5'd18, 31'h1FFFFFFE);
    sendFrame(29'h1, 1'b1);
    check("R4 private mask slot 15", 16'hC000);
    // R6: disabled and wrong-format slots never match
    regWrite(5'd14, {1'b0, 1'b1, 29'h0});
    regWrite(5'd15, {1'b1, 1'b0, 29'h0});
    sendFrame(29'h1, 1'b1);
    check("R6 enable and format", 16'h0);
    // R8: hold across writes without a strobe
    sendFrame(29'h0, 1'b1);
    check("R8 capture", 16'h3FFF);
    regWrite(5'd0, {1'b0, 1'b1, 29'h0});
    regWrite(5'd1, {1'b0, 1'b1, 29'h0});
    repeat (3) @(negedge clk);
    check("R8 hold across writes", 16'h3FFF);
    sendFrame(29'h0, 1'b1);
    check("R8 fresh result lowest index", 16'h3FFC);

    // R5: standard window
    resetAll();
    regWrite(5'd1, {1'b1, 1'b0, 11'h5A5, 18'h0});
    regWrite(5'd2, {1'b1, 1'b1, 11'h5A5, 18'h0});
    sendFrame({11'h5A5, 18'h3FFFF}, 1'b0);
    check("R5 standard ignores low bits", 16'h0002);
    sendFrame({11'h5A5, 18'h3FFFF}, 1'b1);
    check("R5 extended compares all bits", 16'h0);
    sendFrame({11'h5A4, 18'h0}, 1'b0);
    check("R5 standard bit differs", 16'h0);

    // R3 R7 sweep under random configurations
    for (int blk = 0; blk < 40; blk++) begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] r = rnd();
        regWrite(5'(i), {r[1:0] != 2'b00, r[2], 29'(rnd())});
      end
      for (int m = 0; m < 3; m++) regWrite(5'(16 + m), 31'(rnd() & rnd() & rnd()));
      for (int f = 0; f < 40; f++) begin
        logic [31:0] r  = rnd();
        logic [3:0]  b  = r[3:0];
        logic        fi = (r[7:4] == 4'h0) ? ~sIde[b] : sIde[b];
        logic [28:0] fid = sId[b] ^ 29'(rnd() & rnd() & rnd() & rnd());
        sendFrame(fid, fi);
        check("R3 R7 sweep", modelVec(fid, fi));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule